// File: doc/BRIEF.md
# Interval Timer Counter Channel

This block is one channel of a PC-style programmable interval timer: a 16-bit binary down-counter that software loads and reads through an 8-bit data port and configures with 8-bit control words. A clock-enable input, `tick_en`, stands in for the slow timer clock (nominally near 1.19 MHz), so the counter moves once per system clock in which the enable is high. The output pin `timer_out` follows one of three counting modes: a one-shot that rises at terminal count (mode 0), a rate generator that drops low for one tick per period (mode 2) and a square wave (mode 3).

The count is written as two bytes, low first. The low byte halts the channel, and the high byte arms it. Reads also alternate low then high. A latch command freezes a snapshot of the count, and reads return that snapshot until both its bytes have been taken. Control words that ask for anything this channel does not implement are dropped, and `cfg_err` is pulsed. The control word layout is: bits [7:6] select, bits [5:4] access (00 = latch, 11 = low then high), bits [3:1] mode, bit [0] BCD. The channel responds to the select value given by the parameter `CHAN_SEL` (default 0).

Read data leaves on a valid-only stream: `rd_valid` is high for exactly one cycle, one cycle after each `data_re` strobe. There is no ready, so the consumer must take every beat and cannot apply back-pressure.

Top module: `pit_channel`

## Requirements
- R1: After reset, `timer_out`, `cfg_err` and `rd_valid` are low, the mode is 0, the count is 0, and the counter is stopped.
- R2: Data writes alternate low byte, then high byte. A low-byte write replaces count bits [7:0], stops the counter, and drives `timer_out` low in the next cycle.
- R3: A high-byte write completes the 16-bit count and stores it as the period. A nonzero value starts the count, and a zero value leaves the counter stopped. A running counter decrements once per cycle with `tick_en` high and holds otherwise. `timer_out` changes only on an enabled tick, a data write or a control word.
- R4: In mode 0, `timer_out` stays low after the load and rises on the N-th enabled tick for a load of N. It then stays high, and the count stays at 0.
- R5: In mode 2, `timer_out` goes high at the load. It is low exactly while the count is 1. On the tick after that, the count reloads from the period.
- R6: In mode 3, `timer_out` is high while the count is above period/2 (rounded down) and low otherwise. It reloads from the period after 1, which gives ceil(P/2) high ticks and floor(P/2) low ticks.
- R7: Each `data_re` pulse gives one `rd_valid` beat in the next cycle. Without a latch pending, the beats return the live count, low byte then high byte.
- R8: A control word with access 00 and a matching select copies the current count into a snapshot, taking the value before any decrement in that same cycle. It also points reads at the low byte. The snapshot is returned low then high, and the second read releases it. A latch command issued while a snapshot is pending has no effect.
- R9: A control word is rejected, with `cfg_err` high in the next cycle and the mode and count unaffected, when any of these holds: the select is 11; the select matches and the access is 01 or 10; the select matches and BCD is 1; or the select matches and the mode is not 0, 2 or 3. A valid word for another select is ignored without error.
- R10: An accepted control word sets the mode, stops the counter, resets both byte pointers to low, and drives `timer_out` low for mode 0 or high for modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable, one count step per high cycle |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_word | input | 8 | Control word (select, access, mode, BCD) |
| data_we | input | 1 | Data port write strobe |
| data_wdata | input | 8 | Count byte being written |
| data_re | input | 1 | Data port read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after `data_re` |
| rd_data | output | 8 | Returned count byte |
| timer_out | output | 1 | Counter output pin |
| cfg_err | output | 1 | One-cycle pulse on a rejected control word |

## Verification
The collision that matters most is a latch command arriving in the same cycle as an enabled tick. The bench issues the latch word with `tick_en` held high, then keeps ticking and reads back. The snapshot must show the value from before that tick, while the live count afterward must show every tick, including the colliding one. A second collision, a repeated latch arriving while a snapshot is only half read, is checked by expecting the old snapshot's high byte, not a new capture.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    PIT_M_TC   = 3'd0,
    PIT_M_RATE = 3'd2,
    PIT_M_SQW  = 3'd3
  } pit_mode_e;

  typedef struct packed {
    logic      latch;
    logic      cfg;
    logic      err;
    pit_mode_e mode;
  } cw_dec_t;

  localparam logic [1:0] SEL_READBACK = 2'b11;
  localparam logic [1:0] ACC_LATCH    = 2'b00;
  localparam logic [1:0] ACC_LOHI     = 2'b11;

  function automatic cw_dec_t cw_decode(input logic [7:0] w, input logic [1:0] my_sel);
    cw_dec_t d;
    logic mode_ok;
    d.latch = 1'b0;
    d.cfg   = 1'b0;
    d.err   = 1'b0;
    d.mode  = PIT_M_TC;
    mode_ok = 1'b0;
    case (w[3:1])
      3'd0: begin d.mode = PIT_M_TC;   mode_ok = 1'b1; end
      3'd2: begin d.mode = PIT_M_RATE; mode_ok = 1'b1; end
      3'd3: begin d.mode = PIT_M_SQW;  mode_ok = 1'b1; end
      default: mode_ok = 1'b0;
    endcase
    if (w[7:6] == SEL_READBACK) begin
      d.err = 1'b1;
    end else if (w[7:6] == my_sel) begin
      if (w[5:4] == ACC_LATCH) d.latch = 1'b1;
      else if ((w[5:4] != ACC_LOHI) || w[0] || !mode_ok) d.err = 1'b1;
      else d.cfg = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_word,
  output logic       latch_cmd,
  output logic       cfg_valid,
  output pit_mode_e  cfg_mode,
  output logic       cfg_err
);

  cw_dec_t dec;
  logic    err_q;

  always_comb begin
    dec       = cw_decode(ctrl_word, CHAN_SEL);
    latch_cmd = ctrl_we & dec.latch;
    cfg_valid = ctrl_we & dec.cfg;
    cfg_mode  = dec.mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= ctrl_we & dec.err;
  end

  assign cfg_err = err_q;

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic                  cfg_valid,
  input  pit_mode_e             cfg_mode,
  input  logic                  wr_en,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [2*BYTE_W-1:0]   count_o,
  output logic                  out_o,
  output pit_mode_e             mode_o,
  output logic                  wptr_hi_o
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q, period_q, nxt, full;
  logic             running_q, wptr_q, out_q, nxt_out;
  pit_mode_e        mode_q;

  always_comb begin
    full = {wr_data, count_q[BYTE_W-1:0]};
    if (mode_q == PIT_M_TC) nxt = count_q - ONE;
    else                    nxt = (count_q == ONE) ? period_q : count_q - ONE;
    case (mode_q)
      PIT_M_TC:   nxt_out = (nxt == '0);
      PIT_M_RATE: nxt_out = (nxt != ONE);
      default:    nxt_out = (nxt > (period_q >> 1));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      period_q  <= '0;
      running_q <= 1'b0;
      wptr_q    <= 1'b0;
      out_q     <= 1'b0;
      mode_q    <= PIT_M_TC;
    end else if (cfg_valid) begin
      mode_q    <= cfg_mode;
      running_q <= 1'b0;
      wptr_q    <= 1'b0;
      out_q     <= (cfg_mode != PIT_M_TC);
    end else if (wr_en) begin
      if (!wptr_q) begin
        count_q[BYTE_W-1:0] <= wr_data;
        running_q <= 1'b0;
        out_q     <= 1'b0;
        wptr_q    <= 1'b1;
      end else begin
        count_q   <= full;
        period_q  <= full;
        running_q <= (full != '0);
        out_q     <= (full != '0) && (mode_q != PIT_M_TC);
        wptr_q    <= 1'b0;
      end
    end else if (tick_en && running_q) begin
      count_q <= nxt;
      out_q   <= nxt_out;
      if (mode_q == PIT_M_TC && nxt == '0) running_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign out_o     = out_q;
  assign mode_o    = mode_q;
  assign wptr_hi_o = wptr_q;

endmodule

// File: rtl/pit_readback.sv
module pit_readback #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch_cmd,
  input  logic                ptr_clr,
  input  logic                rd_en,
  input  logic [2*BYTE_W-1:0] count_i,
  output logic                rd_valid,
  output logic [BYTE_W-1:0]   rd_data
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  snap_q, src;
  logic              pend_q, rptr_q, valid_q;
  logic [BYTE_W-1:0] data_q;

  assign src = pend_q ? snap_q : count_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= '0;
      pend_q  <= 1'b0;
      rptr_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) begin
        data_q <= rptr_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        rptr_q <= ~rptr_q;
        if (pend_q && rptr_q) pend_q <= 1'b0;
      end
      if (latch_cmd && !pend_q) begin
        pend_q <= 1'b1;
        snap_q <= count_i;
        rptr_q <= 1'b0;
      end
      if (ptr_clr) rptr_q <= 1'b0;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter logic [1:0] CHAN_SEL = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_word,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] data_wdata,
  input  logic              data_re,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  output logic              timer_out,
  output logic              cfg_err
);

  localparam int CNT_W = 2 * BYTE_W;

  logic             latch_cmd, cfg_valid, wptr_hi;
  pit_mode_e        cfg_mode, cur_mode;
  logic [CNT_W-1:0] count;

  pit_ctrl_decode #(.CHAN_SEL(CHAN_SEL)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_word(ctrl_word),
    .latch_cmd(latch_cmd), .cfg_valid(cfg_valid), .cfg_mode(cfg_mode),
    .cfg_err(cfg_err)
  );

  pit_down_counter #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_valid(cfg_valid),
    .cfg_mode(cfg_mode), .wr_en(data_we), .wr_data(data_wdata),
    .count_o(count), .out_o(timer_out), .mode_o(cur_mode), .wptr_hi_o(wptr_hi)
  );

  pit_readback #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .latch_cmd(latch_cmd), .ptr_clr(cfg_valid),
    .rd_en(data_re), .count_i(count), .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       ctrl_we,
  input logic [7:0] ctrl_word,
  input logic       data_we,
  input logic       data_re,
  input logic       rd_valid,
  input logic       timer_out,
  input logic       cfg_err,
  input logic       wptr_hi,
  input pit_mode_e  cur_mode
);

  AST_RD_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    data_re |=> rd_valid); // R7

  AST_RD_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    !data_re |=> !rd_valid); // R7

  AST_LOW_WR_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ctrl_we && !wptr_hi) |=> !timer_out); // R2

  AST_IDLE_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ctrl_we && !data_we) |=> $stable(timer_out)); // R3

  AST_SEL3_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_word[7:6] == 2'b11) |=> cfg_err); // R9

  AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $stable(cur_mode)); // R9

endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_we(ctrl_we),
  .ctrl_word(ctrl_word), .data_we(data_we), .data_re(data_re),
  .rd_valid(rd_valid), .timer_out(timer_out), .cfg_err(cfg_err),
  .wptr_hi(wptr_hi), .cur_mode(cur_mode)
);

// File: tb/pit_channel_tb_top.sv
`timescale 1ns/1ps
module pit_channel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_word = 8'h00;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = 8'h00;
  logic       data_re = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       timer_out;
  logic       cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pit_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_we(ctrl_we),
    .ctrl_word(ctrl_word), .data_we(data_we), .data_wdata(data_wdata),
    .data_re(data_re), .rd_valid(rd_valid), .rd_data(rd_data),
    .timer_out(timer_out), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as read beats appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected beat actual=%h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), {8'h00, rd_data}, {8'h00, exp_q.pop_front()});
      end
    end
  end

  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk) data_re = 1'b1;
    @(negedge clk) data_re = 1'b0;
  endtask

  task automatic wctl(input logic [7:0] w);
    @(negedge clk) begin ctrl_we = 1'b1; ctrl_word = w; end
    @(negedge clk) ctrl_we = 1'b0;
  endtask

  task automatic wdat(input logic [7:0] b);
    @(negedge clk) begin data_we = 1'b1; data_wdata = b; end
    @(negedge clk) data_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
    end
    @(negedge clk) tick_en = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out", {15'd0, timer_out}, 16'd0);
    chk("R1 err", {15'd0, cfg_err}, 16'd0);
    chk("R1 valid", {15'd0, rd_valid}, 16'd0);
    rd(8'h00, "R1 count lo");
    rd(8'h00, "R1 count hi");

    // mode 0 one-shot, load 5
    wctl(8'h30);
    chk("R10 mode0 out low", {15'd0, timer_out}, 16'd0);
    chk("R10 no err", {15'd0, cfg_err}, 16'd0);
    wdat(8'h05);
    wdat(8'h00);
    rd(8'h05, "R3 held without tick lo");
    rd(8'h00, "R7 live hi");
    ticks(4);
    chk("R4 out low before N", {15'd0, timer_out}, 16'd0);
    rd(8'h01, "R3 one per tick");
    rd(8'h00, "R3 hi");
    ticks(1);
    chk("R4 out high at N", {15'd0, timer_out}, 16'd1);
    ticks(3);
    chk("R4 out stays high", {15'd0, timer_out}, 16'd1);
    rd(8'h00, "R4 count held 0 lo");
    rd(8'h00, "R4 count held 0 hi");

    // low byte forces low and stops
    wdat(8'h34);
    chk("R2 low byte forces out low", {15'd0, timer_out}, 16'd0);
    ticks(2);
    rd(8'h34, "R2 stopped lo");
    rd(8'h00, "R2 stopped hi");
    wdat(8'h12);
    ticks(3);
    // latch command colliding with a tick
    @(negedge clk) begin ctrl_we = 1'b1; ctrl_word = 8'h00; tick_en = 1'b1; end
    @(negedge clk) begin ctrl_we = 1'b0; tick_en = 1'b0; end
    ticks(5);
    rd(8'h31, "R8 snapshot lo pre-tick");
    ticks(2);
    wctl(8'h00);
    rd(8'h12, "R8 snapshot hi, second latch ignored");
    rd(8'h29, "R8 released live lo");
    rd(8'h12, "R8 released live hi");

    // rejected control words
    wctl(8'hC0); chk("R9 sel readback err", {15'd0, cfg_err}, 16'd1);
    @(negedge clk); chk("R9 err is a pulse", {15'd0, cfg_err}, 16'd0);
    wctl(8'h10); chk("R9 access lo-only err", {15'd0, cfg_err}, 16'd1);
    wctl(8'h20); chk("R9 access hi-only err", {15'd0, cfg_err}, 16'd1);
    wctl(8'h31); chk("R9 bcd err", {15'd0, cfg_err}, 16'd1);
    wctl(8'h32); chk("R9 mode1 err", {15'd0, cfg_err}, 16'd1);
    wctl(8'h38); chk("R9 mode4 err", {15'd0, cfg_err}, 16'd1);
    ticks(1);
    rd(8'h28, "R9 count still running lo");
    rd(8'h12, "R9 count still running hi");
    wctl(8'h70); chk("R9 other select no err", {15'd0, cfg_err}, 16'd0);
    ticks(1);
    rd(8'h27, "R9 other select ignored lo");
    rd(8'h12, "R9 other select ignored hi");

    // mode 2 rate generator, period 3
    wctl(8'h34);
    chk("R10 mode2 out high", {15'd0, timer_out}, 16'd1);
    ticks(2);
    rd(8'h27, "R10 stopped lo");
    rd(8'h12, "R10 stopped hi");
    wdat(8'h03);
    chk("R2 mode2 low byte out low", {15'd0, timer_out}, 16'd0);
    wdat(8'h00);
    chk("R5 out high at load", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R5 t1", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R5 t2 low at 1", {15'd0, timer_out}, 16'd0);
    ticks(1); chk("R5 t3 reload", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R5 t4", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R5 t5 low at 1", {15'd0, timer_out}, 16'd0);
    ticks(1);
    rd(8'h03, "R5 reloaded lo");
    rd(8'h00, "R5 reloaded hi");

    // mode 3 square wave, period 5
    wctl(8'h36);
    chk("R10 mode3 out high", {15'd0, timer_out}, 16'd1);
    wdat(8'h05);
    wdat(8'h00);
    chk("R6 load high", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R6 t1", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R6 t2", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R6 t3", {15'd0, timer_out}, 16'd0);
    ticks(1); chk("R6 t4", {15'd0, timer_out}, 16'd0);
    ticks(1); chk("R6 t5 reload", {15'd0, timer_out}, 16'd1);
    ticks(1); chk("R6 t6", {15'd0, timer_out}, 16'd1);

    // zero load stays stopped
    wctl(8'h30);
    chk("R10 back to mode0 out low", {15'd0, timer_out}, 16'd0);
    wdat(8'h00);
    wdat(8'h00);
    ticks(3);
    chk("R3 zero load out low", {15'd0, timer_out}, 16'd0);
    rd(8'h00, "R3 zero load stopped lo");
    rd(8'h00, "R3 zero load stopped hi");

    repeat (4) @(negedge clk);
    chk("R7 all beats seen", exp_q.size(), 16'd0);
    summary();
  end

endmodule